// File: doc/BRIEF.md
# Set-Associative Instruction Fetch Cache

This block sits between the fetch stage of a pipelined core and a slow line-oriented backing memory. The core presents a fetch address. On a hit the 32-bit instruction word comes back on the next cycle, and the block can accept a new address every cycle. On a miss the block raises a stall toward the core and requests a whole aligned line from memory. It writes the beats into the chosen way and then returns the requested word. No instruction is lost or repeated.

Capacity, associativity and line size are parameters. The default is 4 ways, 64-byte lines and 32 KB, which gives 128 sets. A 2-way 16 KB build and small test builds come from the same source. Replacement keeps one most-recently-used bit per way; empty ways are always filled first. An invalidate-all input empties the cache one set per cycle. Hit and miss event counters are brought out.

Top module: `ifetch_cache`

## Requirements
- R1: With sets = CACHE_BYTES / (LINE_BYTES × NUM_WAYS), a fetch address splits into byte offset (low log2(LINE_BYTES) bits), set index (next log2(sets) bits) and tag (remaining upper bits). Bits [log2(LINE_BYTES)-1:2] select the word in the line. Addresses that differ by a multiple of sets × LINE_BYTES compete for the same set.
- R2: A request accepted at a clock edge that hits returns its word with `fetch_rsp_valid` high in the next cycle. `fetch_stall` stays low, so hits stream one per cycle.
- R3: Each hit and each completed fill sets that way's MRU bit. If this would leave every bit of the set at 1, only the bit of the way just used remains set.
- R4: On a miss the victim is the lowest-numbered invalid way. If every way is valid, the victim is the lowest-numbered way whose MRU bit is 0.
- R5: A miss raises `fetch_stall` from the cycle after acceptance until the fill ends. The block then raises `mem_req_valid` with a line-aligned `mem_req_addr` (low log2(LINE_BYTES) bits zero) and holds both until `mem_req_ready`. No response is given during the fill, and `mem_req_valid` is low after reset.
- R6: A fill takes LINE_BYTES/4 beats of 32 bits, with beat i holding word i of the line. The line becomes valid after the last beat. The requested word is returned the cycle after the last beat, and then `fetch_stall` is low.
- R7: Every accepted request receives exactly one response, in acceptance order, including misses issued back to back.
- R8: A one-cycle pulse on `inv_all` is held pending until no fill is running. It then clears every valid and MRU bit at one set per cycle. `fetch_stall` is high from the pulse through the last set (sets + 1 cycles when idle), and afterwards every address misses.
- R9: `hit_count` and `miss_count` are zero after reset and increase by one for each hit and each miss lookup.
- R10: A request presented while `fetch_stall` is high is ignored. It produces no response, no counter change and no fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Fetch address present |
| fetch_addr | input | ADDR_W | Byte address of the instruction |
| fetch_stall | output | 1 | Request not accepted; core must hold |
| fetch_rsp_valid | output | 1 | Instruction word valid |
| fetch_rsp_word | output | 32 | Instruction word |
| inv_all | input | 1 | Invalidate whole cache (pulse) |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_addr | output | ADDR_W | Line-aligned fill address |
| mem_req_ready | input | 1 | Memory took the fill request |
| mem_beat_valid | input | 1 | Fill beat present |
| mem_beat_data | input | 32 | Fill beat word |
| hit_count | output | CNT_W | Hit events since reset |
| miss_count | output | CNT_W | Miss events since reset |

## Verification
A valid bit or tag that is set wrongly can show up at the ports in two ways. A stale word appears one cycle after acceptance, or a fill appears where a hit was due, and the response latency exposes it on the first request to that set. Wrong MRU bookkeeping cannot be seen at once. It shows only when a later conflicting line evicts the wrong way, so the bench runs conflict chains that bring the mistake out within four or five requests to one set. An invalidation that clears too little or too much changes the stall length at once, and it changes which later requests hit.

// File: rtl/icache_pkg.sv
package icache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_FLUSH = 2'd2
  } ic_state_e;
endpackage

// File: rtl/icache_way_ram.sv
module icache_way_ram #(
  parameter int SETS   = 128,
  parameter int WORDS  = 16,
  parameter int TAG_W  = 19,
  parameter int IDX_W  = 7,
  parameter int WSEL_W = 4
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_set,
  input  logic [WSEL_W-1:0] rd_word,
  output logic [TAG_W-1:0]  tag_q,
  output logic [31:0]       data_q,
  input  logic              wr_en,
  input  logic              wr_tag_en,
  input  logic [IDX_W-1:0]  wr_set,
  input  logic [WSEL_W-1:0] wr_word,
  input  logic [31:0]       wr_data,
  input  logic [TAG_W-1:0]  wr_tag
);
  localparam int DEPTH = SETS * WORDS;

  logic [31:0]      data_mem [DEPTH];
  logic [TAG_W-1:0] tag_mem  [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) data_mem[{wr_set, wr_word}] <= wr_data;
    if (wr_tag_en) tag_mem[wr_set] <= wr_tag;
    if (rd_en) begin
      data_q <= data_mem[{rd_set, rd_word}];
      tag_q  <= tag_mem[rd_set];
    end
  end
endmodule

// File: rtl/icache_plrum.sv
module icache_plrum #(
  parameter int NUM_WAYS = 4,
  parameter int SETS     = 128,
  parameter int IDX_W    = 7,
  parameter int WAY_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    rd_set,
  output logic [NUM_WAYS-1:0] valid_row,
  output logic [NUM_WAYS-1:0] mru_row,
  output logic [WAY_W-1:0]    victim,
  input  logic                touch_en,
  input  logic                fill_en,
  input  logic [IDX_W-1:0]    touch_set,
  input  logic [WAY_W-1:0]    touch_way,
  input  logic                clr_en,
  input  logic [IDX_W-1:0]    clr_set
);
  logic [NUM_WAYS-1:0] valid_q [SETS];
  logic [NUM_WAYS-1:0] mru_q   [SETS];

  // Mark a way as recently used; when the row would saturate keep only it.
  function automatic logic [NUM_WAYS-1:0] plrum_next(
    input logic [NUM_WAYS-1:0] cur, input logic [WAY_W-1:0] way);
    logic [NUM_WAYS-1:0] one, nxt;
    one = '0;
    one[way] = 1'b1;
    nxt = cur | one;
    return (&nxt) ? one : nxt;
  endfunction

  // Empty ways first, then the lowest way not recently used.
  function automatic logic [WAY_W-1:0] pick_victim(
    input logic [NUM_WAYS-1:0] v, input logic [NUM_WAYS-1:0] m);
    logic [WAY_W-1:0] sel;
    logic found;
    sel = '0;
    found = 1'b0;
    for (int w = 0; w < NUM_WAYS; w++)
      if (!found && !v[w]) begin sel = WAY_W'(w); found = 1'b1; end
    for (int w = 0; w < NUM_WAYS; w++)
      if (!found && !m[w]) begin sel = WAY_W'(w); found = 1'b1; end
    return sel;
  endfunction

  assign valid_row = valid_q[rd_set];
  assign mru_row   = mru_q[rd_set];
  assign victim    = pick_victim(valid_row, mru_row);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        mru_q[s]   <= '0;
      end
    end else begin
      if (clr_en) begin
        valid_q[clr_set] <= '0;
        mru_q[clr_set]   <= '0;
      end
      if (touch_en) mru_q[touch_set] <= plrum_next(mru_q[touch_set], touch_way);
      if (fill_en) valid_q[touch_set][touch_way] <= 1'b1;
    end
  end

  AST_MRU_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(&mru_row)); // R3
  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_row[victim] || !mru_row[victim])); // R4
endmodule

// File: rtl/ifetch_cache.sv
module ifetch_cache
  import icache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_WAYS    = 4,
  parameter int LINE_BYTES  = 64,
  parameter int CACHE_BYTES = 32768,
  parameter int CNT_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_stall,
  output logic              fetch_rsp_valid,
  output logic [31:0]       fetch_rsp_word,
  input  logic              inv_all,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_req_ready,
  input  logic              mem_beat_valid,
  input  logic [31:0]       mem_beat_data,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  miss_count
);
  localparam int WORDS  = LINE_BYTES / 4;
  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * NUM_WAYS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int WSEL_W = $clog2(WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int WAY_W  = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);
  localparam logic [IDX_W-1:0]  LAST_SET  = IDX_W'(SETS - 1);

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [WSEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[2 +: WSEL_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WAY_W-1:0] first_way(input logic [NUM_WAYS-1:0] v);
    logic [WAY_W-1:0] r;
    r = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) if (v[w]) r = WAY_W'(w);
    return r;
  endfunction

  ic_state_e state_q;
  logic              lk_valid_q, req_sent_q, rsp_fill_q, inv_pend_q;
  logic [ADDR_W-1:0] lk_addr_q, fill_addr_q;
  logic [WAY_W-1:0]  victim_q;
  logic [WSEL_W-1:0] beat_q;
  logic [IDX_W-1:0]  flush_set_q;
  logic [31:0]       fill_word_q;
  logic [CNT_W-1:0]  hit_cnt_q, miss_cnt_q;

  // Named internal events
  logic                accept, lk_hit, lk_miss, inv_want, beat_take, fill_done, flush_on;
  logic [NUM_WAYS-1:0] hit_vec, valid_row, mru_row;
  logic [WAY_W-1:0]    hit_way, victim;
  logic [TAG_W-1:0]    tag_rd  [NUM_WAYS];
  logic [31:0]         data_rd [NUM_WAYS];

  assign inv_want  = inv_all | inv_pend_q;
  assign lk_miss   = lk_valid_q & ~lk_hit;
  assign fetch_stall = (state_q != ST_IDLE) | lk_miss | inv_want;
  assign accept    = fetch_valid & ~fetch_stall;
  assign beat_take = (state_q == ST_FILL) & req_sent_q & mem_beat_valid;
  assign fill_done = beat_take & (beat_q == LAST_BEAT);
  assign flush_on  = (state_q == ST_FLUSH);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    assign hit_vec[g] = lk_valid_q & valid_row[g] & (tag_rd[g] == tag_of(lk_addr_q));
    icache_way_ram #(
      .SETS(SETS), .WORDS(WORDS), .TAG_W(TAG_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W)
    ) u_ram (
      .clk      (clk),
      .rd_en    (accept),
      .rd_set   (set_of(fetch_addr)),
      .rd_word  (word_of(fetch_addr)),
      .tag_q    (tag_rd[g]),
      .data_q   (data_rd[g]),
      .wr_en    (beat_take && (victim_q == WAY_W'(g))),
      .wr_tag_en(fill_done && (victim_q == WAY_W'(g))),
      .wr_set   (set_of(fill_addr_q)),
      .wr_word  (beat_q),
      .wr_data  (mem_beat_data),
      .wr_tag   (tag_of(fill_addr_q))
    );
  end

  assign lk_hit  = |hit_vec;
  assign hit_way = first_way(hit_vec);

  icache_plrum #(
    .NUM_WAYS(NUM_WAYS), .SETS(SETS), .IDX_W(IDX_W), .WAY_W(WAY_W)
  ) u_repl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_set   (set_of(lk_addr_q)),
    .valid_row(valid_row),
    .mru_row  (mru_row),
    .victim   (victim),
    .touch_en (lk_hit | fill_done),
    .fill_en  (fill_done),
    .touch_set(fill_done ? set_of(fill_addr_q) : set_of(lk_addr_q)),
    .touch_way(fill_done ? victim_q : hit_way),
    .clr_en   (flush_on),
    .clr_set  (flush_set_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      lk_valid_q  <= 1'b0;
      lk_addr_q   <= '0;
      fill_addr_q <= '0;
      victim_q    <= '0;
      beat_q      <= '0;
      req_sent_q  <= 1'b0;
      rsp_fill_q  <= 1'b0;
      inv_pend_q  <= 1'b0;
      flush_set_q <= '0;
      fill_word_q <= '0;
      hit_cnt_q   <= '0;
      miss_cnt_q  <= '0;
    end else begin
      rsp_fill_q <= 1'b0;
      lk_valid_q <= accept;
      if (accept) lk_addr_q <= fetch_addr;
      if (lk_hit) hit_cnt_q <= hit_cnt_q + 1'b1;
      if (inv_all) inv_pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (lk_miss) begin
            state_q     <= ST_FILL;
            fill_addr_q <= lk_addr_q;
            victim_q    <= victim;
            beat_q      <= '0;
            req_sent_q  <= 1'b0;
            miss_cnt_q  <= miss_cnt_q + 1'b1;
          end else if (inv_want) begin
            state_q     <= ST_FLUSH;
            flush_set_q <= '0;
            inv_pend_q  <= 1'b0;
          end
        end
        ST_FILL: begin
          if (mem_req_valid && mem_req_ready) req_sent_q <= 1'b1;
          if (beat_take) begin
            beat_q <= beat_q + 1'b1;
            if (beat_q == word_of(fill_addr_q)) fill_word_q <= mem_beat_data;
            if (fill_done) begin
              state_q    <= ST_IDLE;
              rsp_fill_q <= 1'b1;
            end
          end
        end
        ST_FLUSH: begin
          flush_set_q <= flush_set_q + 1'b1;
          if (flush_set_q == LAST_SET) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_req_valid   = (state_q == ST_FILL) & ~req_sent_q;
  assign mem_req_addr    = {fill_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign fetch_rsp_valid = rsp_fill_q | lk_hit;
  assign fetch_rsp_word  = rsp_fill_q ? fill_word_q : data_rd[hit_way];
  assign hit_count       = hit_cnt_q;
  assign miss_count      = miss_cnt_q;

  AST_SINGLE_HIT_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R2
  AST_NO_RSP_IN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> !fetch_rsp_valid); // R5
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R5
  AST_LAST_BEAT_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> (fetch_rsp_valid && state_q == ST_IDLE)); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_on |-> (fetch_stall && !fetch_rsp_valid && !mem_req_valid)); // R8
endmodule

// File: tb/ifetch_cache_tb.sv
module ifetch_cache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS  = 4;
  localparam int LINE  = 64;
  localparam int BYTES = 1024;
  localparam int SETS  = BYTES / (LINE * WAYS);
  localparam int WPL   = LINE / 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_stall, fetch_rsp_valid;
  logic [31:0] fetch_rsp_word;
  logic        inv_all = 1'b0;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_req_ready = 1'b0;
  logic        mem_beat_valid = 1'b0;
  logic [31:0] mem_beat_data = '0;
  logic [31:0] hit_count, miss_count;

  ifetch_cache #(
    .ADDR_W(32), .NUM_WAYS(WAYS), .LINE_BYTES(LINE), .CACHE_BYTES(BYTES), .CNT_W(32)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_stall(fetch_stall), .fetch_rsp_valid(fetch_rsp_valid),
    .fetch_rsp_word(fetch_rsp_word), .inv_all(inv_all),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_req_ready(mem_req_ready), .mem_beat_valid(mem_beat_valid),
    .mem_beat_data(mem_beat_data), .hit_count(hit_count), .miss_count(miss_count)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit noise_en = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct packed {
    logic [31:0] word;
    logic        hit;
    logic [31:0] cyc;
  } exp_t;
  exp_t exp_q[$];

  // Reference model of the cache contents
  bit          m_valid [SETS][WAYS];
  bit          m_mru   [SETS][WAYS];
  logic [31:0] m_line  [SETS][WAYS];
  int          m_hits = 0;
  int          m_miss = 0;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return (a & 32'hFFFF_FFFC) * 32'h9E37_79B1 ^ 32'h5A17_C3E9;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic model_touch(input int s, input int w);
    int n;
    m_mru[s][w] = 1'b1;
    n = 0;
    for (int k = 0; k < WAYS; k++) n += m_mru[s][k];
    if (n == WAYS) for (int k = 0; k < WAYS; k++) m_mru[s][k] = (k == w);
  endtask

  task automatic model_access(input logic [31:0] a, output bit hit);
    int s, v;
    logic [31:0] ln;
    s  = (a / LINE) % SETS;
    ln = a / LINE;
    hit = 1'b0;
    for (int w = 0; w < WAYS; w++)
      if (m_valid[s][w] && m_line[s][w] == ln) begin
        hit = 1'b1;
        model_touch(s, w);
      end
    if (hit) m_hits++;
    else begin
      m_miss++;
      v = -1;
      for (int w = 0; w < WAYS; w++) if (v < 0 && !m_valid[s][w]) v = w;
      for (int w = 0; w < WAYS; w++) if (v < 0 && !m_mru[s][w]) v = w;
      m_valid[s][v] = 1'b1;
      m_line[s][v]  = ln;
      model_touch(s, v);
    end
  endtask

  // Driver: present address, hold while stalled (junk address when noise_en)
  task automatic issue(input logic [31:0] a);
    bit h;
    exp_t e;
    fetch_valid = 1'b1;
    fetch_addr  = a;
    #1;
    while (fetch_stall) begin
      if (noise_en) fetch_addr = a ^ 32'h0000_0A80; // R10 ignored while stalled
      @(negedge clk);
      fetch_addr = a;
      #1;
    end
    model_access(a, h);
    e.word = mem_word(a);
    e.hit  = h;
    e.cyc  = cyc;
    exp_q.push_back(e);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while ((exp_q.size() != 0 || fetch_stall) && n < 200) begin
      @(negedge clk);
      n++;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_counts(input string tag);
    check(hit_count == m_hits, {"R9 hit_count ", tag}, hit_count, m_hits);
    check(miss_count == m_miss, {"R9 miss_count ", tag}, miss_count, m_miss);
  endtask

  // Monitor: compare responses in order against the scoreboard
  always @(negedge clk) begin
    if (rst_n && fetch_rsp_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7/R10 unexpected response", fetch_rsp_word, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(fetch_rsp_word == e.word, "R7 response word", fetch_rsp_word, e.word);
        if (e.hit)
          check(cyc == e.cyc + 1, "R2 hit latency", cyc, e.cyc + 1);
        else
          check(cyc >= e.cyc + 1 + WPL, "R5 miss must stall for a fill", cyc, e.cyc + 1 + WPL);
      end
    end
  end

  // Memory model: accept request, wait, stream one line
  initial begin
    logic [31:0] la;
    forever begin
      @(negedge clk);
      if (rst_n && mem_req_valid) begin
        la = mem_req_addr;
        check(la[5:0] == 6'd0, "R5 line-aligned fill address", la, {la[31:6], 6'd0});
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (3) @(negedge clk);
        for (int b = 0; b < WPL; b++) begin
          mem_beat_valid = 1'b1;
          mem_beat_data  = mem_word(la + 32'(4 * b)); // R6 beat i = word i
          if (b == WPL - 1) check(fetch_stall == 1'b1, "R5 stall during fill", fetch_stall, 1);
          @(negedge clk);
        end
        mem_beat_valid = 1'b0;
      end
    end
  end

  task automatic run_all();
    int n;
    // Reset state
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(fetch_stall == 1'b0, "R5 no stall after reset", fetch_stall, 0);
    check(mem_req_valid == 1'b0, "R5 no fill request after reset", mem_req_valid, 0);
    check(fetch_rsp_valid == 1'b0, "R7 no response after reset", fetch_rsp_valid, 0);
    check_counts("after reset");
    @(negedge clk);

    // Cold miss then streaming hits over the same line (R2, R6)
    for (int i = 0; i < WPL; i++) issue(32'h0000_0000 + 32'(4 * i));
    drain();
    check_counts("line stream");

    // Miss on a word in the middle of a line (R6 critical word)
    issue(32'h0000_1034);
    issue(32'h0000_1000);
    issue(32'h0000_103C);
    drain();

    // Conflict chain in set 1, alias stride sets*line (R1, R3, R4, R7)
    issue(32'h0000_0040);
    issue(32'h0000_0140);
    issue(32'h0000_0240);
    issue(32'h0000_0340);
    issue(32'h0000_0044);
    issue(32'h0000_0440);
    issue(32'h0000_0148);
    issue(32'h0000_024C);
    issue(32'h0000_0350);
    issue(32'h0000_0054);
    drain();
    check_counts("conflict chain R3 R4");

    // Requests wiggled while stalled must be ignored (R10)
    noise_en = 1'b1;
    issue(32'h0000_0580);
    issue(32'h0000_0684);
    issue(32'h0000_0588);
    noise_en = 1'b0;
    drain();
    check_counts("after stalled noise R10");

    // Invalidate-all pulse: stall length and later misses (R8)
    repeat (3) @(negedge clk);
    inv_all = 1'b1;
    #1;
    n = fetch_stall ? 1 : 0;
    @(negedge clk);
    inv_all = 1'b0;
    #1;
    while (fetch_stall && n < 1000) begin
      n++;
      @(negedge clk);
      #1;
    end
    check(n == SETS + 1, "R8 invalidate stall length", n, SETS + 1);
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin
        m_valid[s][w] = 1'b0;
        m_mru[s][w] = 1'b0;
      end
    @(negedge clk);
    issue(32'h0000_0000);
    issue(32'h0000_0044);
    drain();
    check_counts("after invalidate R8");

    // Random mix with aliasing, back-to-back misses (R3, R4, R7, R9)
    for (int i = 0; i < 300; i++) issue(32'($urandom_range(0, 1023)) * 4);
    drain();
    check_counts("random mix");
    check(exp_q.size() == 0, "R7 all responses received", exp_q.size(), 0);
  endtask

  initial begin
    bit wd;
    wd = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule